// File: doc/BRIEF.md
# Ring Buffer Occupancy and Wrap Unit

This unit sits in front of a memory read engine that drains a ring buffer held in ordinary memory and used as a DMA FIFO. The ring is described by a base address and a size mask. The producer side publishes its current write address. The consumer asks to read a number of 16-byte quadwords starting at its drain address. The unit checks whether that drain address lies inside the ring. It measures how many quadwords the producer has made available, including the case where the producer pointer has already wrapped past the top. It then trims the request to what is available.

The trimmed burst is handed to the read engine as one or two contiguous segments, each given as a start address and a count of 32-bit words. When the burst would run past the top of the ring, it is split. The first segment runs up to the top and the second segment restarts at the wrapped address. A drain address outside the ring is passed through untouched at the full requested size. Segments leave through a registered valid/ready port, and a new request is taken only after the previous burst has been fully handed off.

Top module: `ring_occ_wrap`

## Requirements
- R1: The restart address of a split burst is the ring wrap of the ring top, computed as base + (address AND mask). For a base aligned to the ring size, this is the base itself.
- R2: A drain address counts as inside the ring only when base <= address < base + mask + 16. Outside the ring, the request is granted in full as one segment at the unchanged address with requested-quadwords x 4 words.
- R3: When the drain address is at or below the producer address, the available count is (producer - drain) >> 4 quadwords.
- R4: When the drain address is above the producer address, the available count is ((producer - base) + (top - drain)) >> 4, where top = base + mask + 16.
- R5: The granted count is the smaller of the requested and available quadword counts. A request granted zero is accepted and emits no segment.
- R6: When drain + granted x 16 exceeds the top, the burst leaves as two segments. The first starts at the drain address and carries (top - drain) / 4 words. The second carries granted x 4 minus that number of words.
- R7: When drain + granted x 16 equals the top exactly, the burst leaves as a single segment of granted x 4 words.
- R8: While seg_valid is high and seg_ready is low, seg_addr, seg_words and seg_last hold steady. seg_last is 1 only on the final segment of a burst. A second segment appears in the cycle after the first is accepted.
- R9: After reset, seg_valid is 0 and req_ready is 1. req_ready is 0 whenever a segment is pending.
- R10: When the drain address equals the producer address, the ring is empty and the request emits no segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Ring base address, aligned to ring size |
| cfg_mask | input | 32 | Ring offset mask, contiguous low bits, low 4 bits zero |
| prod_addr | input | 32 | Producer write address |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 32 | Drain (read) address of the request |
| req_qwc | input | 16 | Requested quadword count |
| seg_valid | output | 1 | Segment present on the output |
| seg_ready | input | 1 | Read engine accepts the segment |
| seg_addr | output | 32 | Segment start byte address |
| seg_words | output | 18 | Segment length in 32-bit words |
| seg_last | output | 1 | Final segment of the burst |

## Verification
Several drain/producer pairings are applied to the unit. The first is a pairing where the producer is ahead of the drain without wrap and the request is smaller than availability, so it checks the plain subtraction. The second is the same pairing with a request larger than availability, which confirms that the minimum is taken. The third has the drain equal to the producer, which shows the empty case produces nothing. A wrapped producer with a burst crossing the top separates the two-segment path from the single-segment one. A burst ending exactly at the top catches an off-by-one in the split compare. Drain addresses at the top and below the base confirm the bypass path, and a second ring geometry confirms the wrap uses the configured mask and base. A held-off first segment of a split burst shows the output holds steady and the restart segment follows in order.

// File: rtl/ring_pkg.sv
package ring_pkg;

  localparam int AW      = 32;        // address width
  localparam int QW      = 16;        // quadword count width
  localparam int WW      = QW + 2;    // word count width (quadwords x 4)
  localparam int QB_LOG2 = 4;         // bytes per quadword, log2
  localparam int WB_LOG2 = 2;         // bytes per word, log2
  localparam int QBYTES  = 1 << QB_LOG2;

  typedef logic [AW-1:0] addr_t;
  typedef logic [QW-1:0] qwc_t;
  typedef logic [WW-1:0] words_t;

  typedef struct packed {
    addr_t  addr;
    words_t words;
    logic   last;
  } seg_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } issue_st_e;

  // Fold an address into the ring.
  function automatic addr_t ring_wrap(addr_t base, addr_t mask, addr_t a);
    return base + (a & mask);
  endfunction

  // Exclusive upper byte limit of the ring.
  function automatic addr_t ring_top(addr_t base, addr_t mask);
    return base + mask + addr_t'(QBYTES);
  endfunction

  // Membership test used for the occupancy bypass.
  function automatic logic ring_holds(addr_t base, addr_t mask, addr_t a);
    return (a >= base) && (a < ring_top(base, mask));
  endfunction

  // Bytes the producer is ahead of the drain, wrapped or not.
  function automatic addr_t ring_fill_bytes(addr_t base, addr_t mask,
                                            addr_t prod, addr_t drain);
    if (drain <= prod)
      return prod - drain;
    else
      return (prod - base) + (ring_top(base, mask) - drain);
  endfunction

endpackage

// File: rtl/ring_occupancy.sv
module ring_occupancy
  import ring_pkg::*;
(
  input  addr_t base,
  input  addr_t mask,
  input  addr_t prod,
  input  addr_t drain,
  output logic  in_ring,
  output logic  wrapped_case,
  output addr_t avail_qw
);

  addr_t fill_bytes;

  always_comb begin
    in_ring      = ring_holds(base, mask, drain);
    wrapped_case = drain > prod;
    fill_bytes   = ring_fill_bytes(base, mask, prod, drain);
    avail_qw     = fill_bytes >> QB_LOG2;
  end

endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
  import ring_pkg::*;
(
  input  addr_t base,
  input  addr_t mask,
  input  addr_t drain,
  input  qwc_t  req_qwc,
  input  logic  in_ring,
  input  addr_t avail_qw,
  output qwc_t  grant_qwc,
  output logic  has_data,
  output logic  split,
  output seg_t  seg0,
  output seg_t  seg1
);

  addr_t          top;
  logic [AW:0]    end_b;
  logic [AW:0]    top_b;
  words_t         total_words;
  words_t         first_words;

  always_comb begin
    top = ring_top(base, mask);

    if (!in_ring)
      grant_qwc = req_qwc;
    else if (avail_qw < addr_t'(req_qwc))
      grant_qwc = avail_qw[QW-1:0];
    else
      grant_qwc = req_qwc;

    has_data    = grant_qwc != '0;
    total_words = words_t'(grant_qwc) << (QB_LOG2 - WB_LOG2);
    end_b       = {1'b0, drain} + ((AW+1)'(grant_qwc) << QB_LOG2);
    top_b       = {1'b0, top};
    split       = in_ring && (end_b > top_b);
    first_words = words_t'((top - drain) >> WB_LOG2);

    seg0.addr  = in_ring ? ring_wrap(base, mask, drain) : drain;
    seg0.words = split ? first_words : total_words;
    seg0.last  = !split;

    seg1.addr  = ring_wrap(base, mask, top);
    seg1.words = total_words - first_words;
    seg1.last  = 1'b1;
  end

endmodule

// File: rtl/seg_issue.sv
module seg_issue
  import ring_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic has_data,
  input  logic split,
  input  seg_t seg0,
  input  seg_t seg1,
  output logic seg_valid,
  input  logic seg_ready,
  output seg_t seg_out,
  output logic req_fire
);

  issue_st_e st_q;
  seg_t      seg_q;
  seg_t      pend_q;
  logic      pend_v_q;

  always_comb begin
    req_ready = st_q == ST_IDLE;
    seg_valid = st_q == ST_BUSY;
    req_fire  = req_valid && req_ready;
    seg_out   = seg_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      seg_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_fire && has_data) begin
            st_q     <= ST_BUSY;
            seg_q    <= seg0;
            pend_q   <= seg1;
            pend_v_q <= split;
          end
        end
        ST_BUSY: begin
          if (seg_ready) begin
            if (pend_v_q) begin
              seg_q    <= pend_q;
              pend_v_q <= 1'b0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ring_occ_wrap.sv
module ring_occ_wrap
  import ring_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_base,
  input  logic [31:0]   cfg_mask,
  input  logic [31:0]   prod_addr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [31:0]   req_addr,
  input  logic [15:0]   req_qwc,
  output logic          seg_valid,
  input  logic          seg_ready,
  output logic [31:0]   seg_addr,
  output logic [17:0]   seg_words,
  output logic          seg_last
);

  logic   in_ring;
  logic   wrapped_case;
  addr_t  avail_qw;
  qwc_t   grant_qwc;
  logic   has_data;
  logic   split;
  seg_t   seg0;
  seg_t   seg1;
  seg_t   seg_out;
  logic   req_fire;
  words_t seg0_words;
  words_t seg1_words;

  ring_occupancy u_occ (
    .base         (cfg_base),
    .mask         (cfg_mask),
    .prod         (prod_addr),
    .drain        (req_addr),
    .in_ring      (in_ring),
    .wrapped_case (wrapped_case),
    .avail_qw     (avail_qw)
  );

  burst_splitter u_split (
    .base      (cfg_base),
    .mask      (cfg_mask),
    .drain     (req_addr),
    .req_qwc   (req_qwc),
    .in_ring   (in_ring),
    .avail_qw  (avail_qw),
    .grant_qwc (grant_qwc),
    .has_data  (has_data),
    .split     (split),
    .seg0      (seg0),
    .seg1      (seg1)
  );

  seg_issue u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .has_data  (has_data),
    .split     (split),
    .seg0      (seg0),
    .seg1      (seg1),
    .seg_valid (seg_valid),
    .seg_ready (seg_ready),
    .seg_out   (seg_out),
    .req_fire  (req_fire)
  );

  assign seg0_words = seg0.words;
  assign seg1_words = seg1.words;
  assign seg_addr   = seg_out.addr;
  assign seg_words  = seg_out.words;
  assign seg_last   = seg_out.last;

endmodule

// File: rtl/ring_occ_wrap_chk.sv
module ring_occ_wrap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        req_fire,
  input logic        seg_valid,
  input logic        seg_ready,
  input logic [31:0] seg_addr,
  input logic [17:0] seg_words,
  input logic        seg_last,
  input logic [15:0] req_qwc,
  input logic [15:0] grant_qwc,
  input logic        split,
  input logic [17:0] seg0_words,
  input logic [17:0] seg1_words
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) &&
                                $stable(seg_words) && $stable(seg_last));

  p_second_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_ready && !seg_last |=> seg_valid && seg_last);

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !req_ready);

  p_grant_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> grant_qwc <= req_qwc);

  p_nonempty_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> seg_words != '0);

  p_split_halves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && split |-> (seg0_words != '0) && (seg1_words != '0));

endmodule

bind ring_occ_wrap ring_occ_wrap_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .req_fire   (req_fire),
  .seg_valid  (seg_valid),
  .seg_ready  (seg_ready),
  .seg_addr   (seg_addr),
  .seg_words  (seg_words),
  .seg_last   (seg_last),
  .req_qwc    (req_qwc),
  .grant_qwc  (grant_qwc),
  .split      (split),
  .seg0_words (seg0_words),
  .seg1_words (seg1_words)
);

// File: tb/test_ring_occ_wrap.sv
module test_ring_occ_wrap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [31:0] cfg_mask = '0;
  logic [31:0] prod_addr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_qwc = '0;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [31:0] seg_addr;
  logic [17:0] seg_words;
  logic        seg_last;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ring_occ_wrap i_ring_occ_wrap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_base  (cfg_base),
    .cfg_mask  (cfg_mask),
    .prod_addr (prod_addr),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_qwc   (req_qwc),
    .seg_valid (seg_valid),
    .seg_ready (seg_ready),
    .seg_addr  (seg_addr),
    .seg_words (seg_words),
    .seg_last  (seg_last)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] mask;
    logic [31:0] prod;
    logic [31:0] drain;
    logic [15:0] qwc;
    logic [1:0]  nseg;
    logic [31:0] a0;
    logic [17:0] w0;
    logic [31:0] a1;
    logic [17:0] w1;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R3: producer ahead, request below availability
    '{32'h10000, 32'hFF0, 32'h10200, 32'h10100, 16'd8,  2'd1, 32'h10100, 18'd32, 32'h0,     18'd0,  4'd3},
    // R5: request trimmed to availability
    '{32'h10000, 32'hFF0, 32'h10200, 32'h10180, 16'd20, 2'd1, 32'h10180, 18'd32, 32'h0,     18'd0,  4'd5},
    // R10: empty ring, no segment
    '{32'h10000, 32'hFF0, 32'h10300, 32'h10300, 16'd4,  2'd0, 32'h0,     18'd0,  32'h0,     18'd0,  4'd10},
    // R4 R6: wrapped producer, burst crosses top
    '{32'h10000, 32'hFF0, 32'h10040, 32'h10FC0, 16'd10, 2'd2, 32'h10FC0, 18'd16, 32'h10000, 18'd16, 4'd6},
    // R7: burst ends exactly at top
    '{32'h10000, 32'hFF0, 32'h10100, 32'h10F00, 16'd16, 2'd1, 32'h10F00, 18'd64, 32'h0,     18'd0,  4'd7},
    // R4: wrapped, request smaller than availability, split
    '{32'h10000, 32'hFF0, 32'h10800, 32'h10FF0, 16'd3,  2'd2, 32'h10FF0, 18'd4,  32'h10000, 18'd8,  4'd4},
    // R2: drain at top is outside, full grant
    '{32'h10000, 32'hFF0, 32'h10100, 32'h11000, 16'd5,  2'd1, 32'h11000, 18'd20, 32'h0,     18'd0,  4'd2},
    // R2: drain below base is outside
    '{32'h10000, 32'hFF0, 32'h10100, 32'h08000, 16'd2,  2'd1, 32'h08000, 18'd8,  32'h0,     18'd0,  4'd2},
    // R1: other geometry, restart at its own base
    '{32'h40000, 32'h3FF0, 32'h40020, 32'h43FE0, 16'd6, 2'd2, 32'h43FE0, 18'd8,  32'h40000, 18'd8,  4'd1},
    // R3: drain at base
    '{32'h10000, 32'hFF0, 32'h10050, 32'h10000, 16'd9,  2'd1, 32'h10000, 18'd20, 32'h0,     18'd0,  4'd3}
  };

  int          got_n;
  logic [31:0] got_a [2];
  logic [17:0] got_w [2];
  logic        got_l [2];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic run_req(input logic [31:0] d, input logic [15:0] q);
    got_n = 0;
    @(negedge clk);
    req_addr  = d;
    req_qwc   = q;
    req_valid = 1'b1;
    seg_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (seg_valid && got_n < 2) begin
        got_a[got_n] = seg_addr;
        got_w[got_n] = seg_words;
        got_l[got_n] = seg_last;
        got_n++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 seg_valid after reset", {31'b0, seg_valid}, 32'd0);
    check("R9 req_ready after reset", {31'b0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      cfg_base  = VECS[i].base;
      cfg_mask  = VECS[i].mask;
      prod_addr = VECS[i].prod;
      run_req(VECS[i].drain, VECS[i].qwc);
      check({tg, " nseg"}, got_n, {30'b0, VECS[i].nseg});
      if (got_n >= 1 && VECS[i].nseg >= 1) begin
        check({tg, " addr0"}, got_a[0], VECS[i].a0);
        check({tg, " words0"}, {14'b0, got_w[0]}, {14'b0, VECS[i].w0});
        check({tg, " last0"}, {31'b0, got_l[0]}, {31'b0, VECS[i].nseg == 2'd1});
      end
      if (got_n == 2 && VECS[i].nseg == 2'd2) begin
        check({tg, " addr1"}, got_a[1], VECS[i].a1);
        check({tg, " words1"}, {14'b0, got_w[1]}, {14'b0, VECS[i].w1});
        check({tg, " last1"}, {31'b0, got_l[1]}, 32'd1);
      end
    end

    // R8 R9: backpressure on the first segment of a split burst
    cfg_base  = 32'h10000;
    cfg_mask  = 32'hFF0;
    prod_addr = 32'h10040;
    @(negedge clk);
    req_addr  = 32'h10FC0;
    req_qwc   = 16'd10;
    req_valid = 1'b1;
    seg_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 req_ready low while pending", {31'b0, req_ready}, 32'd0);
    check("R8 first seg not last", {31'b0, seg_last}, 32'd0);
    repeat (3) @(negedge clk);
    check("R8 held valid", {31'b0, seg_valid}, 32'd1);
    check("R8 held addr", seg_addr, 32'h10FC0);
    check("R8 held words", {14'b0, seg_words}, 32'd16);
    seg_ready = 1'b1;
    @(negedge clk);
    check("R8 second seg valid", {31'b0, seg_valid}, 32'd1);
    check("R1 second seg addr", seg_addr, 32'h10000);
    check("R6 second seg words", {14'b0, seg_words}, 32'd16);
    check("R8 second seg last", {31'b0, seg_last}, 32'd1);
    @(negedge clk);
    check("R9 idle after burst", {31'b0, req_ready}, 32'd1);
    check("R8 no extra segment", {31'b0, seg_valid}, 32'd0);

    finish_run();
  end

endmodule